// File: doc/BRIEF.md
# Peripheral Clock Disable Controller

This block holds one disable bit per peripheral and turns those bits into per-module clock enables. It also screens bus traffic aimed at the peripherals' own registers. Software writes the disable register through a simple configuration port. The clock enables move to the new value only on the instruction-cycle strobe that follows the write, so each change lands one instruction cycle after it was requested.

A module counts as running only when it exists in the build, given by the `PRESENT` parameter, and its disable bit is clear. While a module is not running, the filter never forwards a bus access to it. Writes therefore vanish, and reads complete with an all-ones word that marks the data as invalid. Bits for modules that are not built are fixed at one.

Top module: `periph_clkgate`

## Requirements
- R1: After reset, each disable bit is 0 for a present module and 1 for an absent one, and `mod_clk_en` equals `PRESENT`.
- R2: The disable bit of an absent module always reads 1 and ignores writes. Its clock enable is never set.
- R3: A write on `cfg_we` updates the disable register at that clock edge, and `cfg_rdata` shows the new value from the next cycle on.
- R4: `mod_clk_en` changes only at a clock edge where `icyc_stb` is high. A strobe at the same edge as a configuration write still uses the old bits, so the new bits need the next strobe.
- R5: At each strobe edge, bit i of `mod_clk_en` becomes 1 exactly when module i is present and its disable bit is 0.
- R6: When `bus_valid` addresses an enabled module, only that module's `mod_req` bit rises in the same cycle. The module index is the top `IDX_W` bits of `bus_addr`, and `mod_off` carries the low bits.
- R7: An access to a disabled or absent module raises no `mod_req` bit, so writes to its registers are dropped.
- R8: A read (`bus_valid` high, `bus_we` low) gives `bus_rvalid` one cycle later. `bus_rdata` holds the addressed module's data if that module is enabled, and all ones otherwise.
- R9: Between a disable write and the strobe that applies it, the module keeps its clock enable and still receives accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| icyc_stb | input | 1 | One-cycle pulse per instruction cycle |
| cfg_we | input | 1 | Write strobe for the disable register |
| cfg_wdata | input | N_MOD | New disable bits, bit i for module i |
| cfg_rdata | output | N_MOD | Current disable bits |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| bus_valid | input | 1 | Peripheral register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Module index (upper bits) and register offset (lower bits) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, all ones when the target is not running |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| mod_req | output | N_MOD | Forwarded access select per module |
| mod_we | output | 1 | Write flag broadcast to modules |
| mod_off | output | ADDR_W-IDX_W | Register offset broadcast to modules |
| mod_wdata | output | DATA_W | Write data broadcast to modules |
| mod_rdata | input | N_MOD*DATA_W | Read data from every module, module i at bits i*DATA_W |

## Verification
The bench writes the disable register at the same edge as a strobe. A design that let the strobe pick up the fresh bits would switch the clocks one instruction cycle early. It also accesses a module in the gap between a disable write and its strobe, where a design that gated on the raw register would drop the access too soon. Accesses to a disabled module and to an absent module are checked for silence on `mod_req` and for all-ones read data, which catches a filter that leaks writes or returns stale data. Writes of zero to an absent module's bit confirm that the bit stays set and that its clock never turns on.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  // index width with a floor of one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pcg_disable_bank.sv
module pcg_disable_bank #(
  parameter int                 N_MOD   = 8,
  parameter logic [N_MOD-1:0]   PRESENT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             icyc_stb,
  input  logic             cfg_we,
  input  logic [N_MOD-1:0] cfg_wdata,
  output logic [N_MOD-1:0] dis_q,
  output logic [N_MOD-1:0] en_q
);

  for (genvar g = 0; g < N_MOD; g++) begin : g_bit
    logic dis_b, en_b;

    always_ff @(posedge clk) begin
      if (rst)         dis_b <= !PRESENT[g];
      else if (cfg_we) dis_b <= PRESENT[g] ? cfg_wdata[g] : 1'b1;
    end

    // the enable samples the disable bit held before this edge
    always_ff @(posedge clk) begin
      if (rst)           en_b <= PRESENT[g];
      else if (icyc_stb) en_b <= PRESENT[g] & ~dis_b;
    end

    assign dis_q[g] = dis_b;
    assign en_q[g]  = en_b;
  end

  a_r2_absent_bits_set: assert property (@(posedge clk) disable iff (rst)
    ((dis_q & ~PRESENT) == ~PRESENT) && ((en_q & ~PRESENT) == '0));

  a_r4_change_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> $past(icyc_stb));

  a_r5_enable_tracks: assert property (@(posedge clk) disable iff (rst)
    $past(icyc_stb) |-> (en_q == (PRESENT & ~$past(dis_q))));

endmodule

// File: rtl/pcg_bus_filter.sv
module pcg_bus_filter
  import pcg_pkg::*;
#(
  parameter int N_MOD  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = idx_width(N_MOD),
  localparam int OFF_W = ADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_MOD-1:0]        en,
  input  logic                    bus_valid,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_rvalid,
  output logic [N_MOD-1:0]        mod_req,
  output logic                    mod_we,
  output logic [OFF_W-1:0]        mod_off,
  output logic [DATA_W-1:0]       mod_wdata,
  input  logic [N_MOD*DATA_W-1:0] mod_rdata
);

  logic [IDX_W-1:0]  idx;
  logic [N_MOD-1:0]  dec;
  logic [DATA_W-1:0] masked [N_MOD];
  logic [DATA_W-1:0] rsel;

  assign idx       = bus_addr[ADDR_W-1 -: IDX_W];
  assign mod_we    = bus_we;
  assign mod_off   = bus_addr[OFF_W-1:0];
  assign mod_wdata = bus_wdata;

  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    assign dec[g]     = (idx == IDX_W'(g));
    assign mod_req[g] = bus_valid & dec[g] & en[g];
    assign masked[g]  = mod_rdata[g*DATA_W +: DATA_W] & {DATA_W{dec[g] & en[g]}};
  end

  always_comb begin
    rsel = '0;
    for (int i = 0; i < N_MOD; i++) rsel = rsel | masked[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_valid & ~bus_we;
      if (bus_valid & ~bus_we)
        bus_rdata <= (|(dec & en)) ? rsel : '1;
    end
  end

  a_r6_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mod_req));

  a_r8_invalid_read: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && ((dec & en) == '0)) |=> (bus_rvalid && bus_rdata == '1));

endmodule

// File: rtl/periph_clkgate.sv
module periph_clkgate
  import pcg_pkg::*;
#(
  parameter int               N_MOD   = 8,
  parameter int               ADDR_W  = 8,
  parameter int               DATA_W  = 16,
  parameter logic [N_MOD-1:0] PRESENT = 8'b1011_1111,
  localparam int IDX_W = idx_width(N_MOD),
  localparam int OFF_W = ADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    icyc_stb,
  input  logic                    cfg_we,
  input  logic [N_MOD-1:0]        cfg_wdata,
  output logic [N_MOD-1:0]        cfg_rdata,
  output logic [N_MOD-1:0]        mod_clk_en,
  input  logic                    bus_valid,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_rvalid,
  output logic [N_MOD-1:0]        mod_req,
  output logic                    mod_we,
  output logic [OFF_W-1:0]        mod_off,
  output logic [DATA_W-1:0]       mod_wdata,
  input  logic [N_MOD*DATA_W-1:0] mod_rdata
);

  logic [N_MOD-1:0] en;

  pcg_disable_bank #(.N_MOD(N_MOD), .PRESENT(PRESENT)) u_bank (
    .clk(clk), .rst(rst), .icyc_stb(icyc_stb),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dis_q(cfg_rdata), .en_q(en)
  );

  pcg_bus_filter #(.N_MOD(N_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_filter (
    .clk(clk), .rst(rst), .en(en),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .mod_req(mod_req), .mod_we(mod_we), .mod_off(mod_off),
    .mod_wdata(mod_wdata), .mod_rdata(mod_rdata)
  );

  assign mod_clk_en = en;

endmodule

// File: tb/periph_clkgate_tb.sv
module periph_clkgate_tb;
  localparam int N = 8, AW = 8, DW = 16, OW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic stb = 1'b0, cfg_we = 1'b0;
  logic [N-1:0] cfg_wdata = '0, cfg_rdata, clk_en, mod_req;
  logic bus_valid = 1'b0, bus_we = 1'b0, bus_rvalid, mod_we;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, mod_wdata;
  logic [OW-1:0] mod_off;
  logic [N*DW-1:0] mod_rdata;

  int checks = 0, fails = 0;

  typedef struct { logic [DW-1:0] data; int mod; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  periph_clkgate u_dut (
    .clk(clk), .rst(rst), .icyc_stb(stb), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mod_clk_en(clk_en), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .mod_req(mod_req), .mod_we(mod_we), .mod_off(mod_off),
    .mod_wdata(mod_wdata), .mod_rdata(mod_rdata)
  );

  function automatic logic [DW-1:0] pval(int m, logic [OW-1:0] off);
    return {4'hA, 4'(m), 3'b0, off};
  endfunction

  always_comb
    for (int i = 0; i < N; i++) mod_rdata[i*DW +: DW] = pval(i, mod_off);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg_write(logic [N-1:0] v, logic with_stb);
    cfg_we = 1'b1; cfg_wdata = v; stb = with_stb;
    cyc();
    cfg_we = 1'b0; stb = 1'b0;
  endtask

  task automatic strobe;
    stb = 1'b1; cyc(); stb = 1'b0;
  endtask

  // write access: the forwarded select is checked within the same cycle
  task automatic bus_write(int m, logic [OW-1:0] off, logic [N-1:0] exp_req, string req);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = {3'(m), off}; bus_wdata = 16'h1234;
    #1;
    chk(req, 32'(mod_req), 32'(exp_req));
    if (exp_req != '0) chk("R6 offset", 32'(mod_off), 32'(off));
    cyc();
    bus_valid = 1'b0;
  endtask

  // read access: expected result goes to the scoreboard
  task automatic bus_read(int m, logic [OW-1:0] off, logic [DW-1:0] exp);
    exp_t e;
    e.data = exp; e.mod = m;
    sb.push_back(e);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = {3'(m), off};
    cyc();
    bus_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb.size() == 0) chk("R8 unexpected rvalid", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk($sformatf("R8 read module %0d", e.mod), 32'(bus_rdata), 32'(e.data));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    chk("R1 disable bits", 32'(cfg_rdata), 32'h40);
    chk("R1 clock enables", 32'(clk_en), 32'hBF);

    // R3 write lands at once, R4 clocks wait for strobe
    cfg_write(8'h05, 1'b0);
    chk("R3 readback", 32'(cfg_rdata), 32'h45);
    chk("R4 no strobe yet", 32'(clk_en), 32'hBF);
    // R9 module 0 still reachable before the strobe
    bus_write(0, 5'd3, 8'h01, "R9 access before strobe");
    chk("R9 clock still on", 32'(clk_en), 32'hBF);
    strobe();
    chk("R5 enables after strobe", 32'(clk_en), 32'hBA);

    // R7 disabled and absent modules
    bus_write(2, 5'd4, 8'h00, "R7 write to disabled");
    bus_write(6, 5'd1, 8'h00, "R7 write to absent");
    bus_write(3, 5'd9, 8'h08, "R6 write to enabled");
    bus_read(2, 5'd4, 16'hFFFF);
    bus_read(1, 5'd7, pval(1, 5'd7));
    bus_read(6, 5'd1, 16'hFFFF);
    bus_read(7, 5'd31, pval(7, 5'd31));
    cyc();

    // R4 write at a strobe edge waits for the next strobe, R2 absent bit sticks
    cfg_write(8'h00, 1'b1);
    chk("R2 absent bit held", 32'(cfg_rdata), 32'h40);
    chk("R4 same-edge strobe ignored", 32'(clk_en), 32'hBA);
    strobe();
    chk("R5 re-enabled", 32'(clk_en), 32'hBF);
    strobe();
    chk("R4 bare strobe no change", 32'(clk_en), 32'hBF);
    bus_read(4, 5'd2, pval(4, 5'd2));
    bus_read(0, 5'd3, pval(0, 5'd3));

    // R5 everything off
    cfg_write(8'hFF, 1'b0);
    chk("R3 all set", 32'(cfg_rdata), 32'hFF);
    strobe();
    chk("R5 all off", 32'(clk_en), 32'h00);
    bus_write(5, 5'd0, 8'h00, "R7 write all off");
    bus_read(3, 5'd5, 16'hFFFF);
    cfg_write(8'h00, 1'b0);
    strobe();
    chk("R2 absent clock stays off", 32'(clk_en), 32'hBF);
    cyc();
    chk("R8 scoreboard drained", 32'(sb.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule